// File: doc/BRIEF.md
# Character Display Controller Register Interface

This block is the processor-facing side of a character-cell display timing controller. A host sees two byte-wide locations. The first is the index location: writing it chooses one of 32 register slots, and reading it returns a status byte. The second is the data location: writing or reading it acts on the slot that is currently chosen. The block keeps the horizontal and vertical timing values, the scan-row and cursor settings, and the display start and cursor addresses. It drives all of these continuously to the timing and cursor logic next to it.

The timing generator is a separate block. It supplies the current character-row count and the live refresh address. From these inputs this block reports vertical blanking in the status byte. It also captures the refresh address when an active-low light-pen strobe arrives, and keeps a sticky flag that the host clears by reading back the captured position. Most timing slots cannot be read back. Slots 18 to 31 are reserved.

Top module: `crtc_regfile`

## Requirements
- R1: A write to the index location (`addr_sel`=0) loads `wdata[4:0]` as the selected slot index. `wdata[7:5]` is ignored.
- R2: A write to the data location (`addr_sel`=1) stores `wdata` in the selected slot 0 to 15, cut to that slot's width, and the value appears on its output port one cycle later. The widths are: slots 0, 1, 2, 3 and 8 keep 8 bits; slots 4, 6, 7 and 10 keep 7 bits; slots 5, 9 and 11 keep 5 bits. Slots 12 and 14 set address bits 13:8 from `wdata[5:0]`. Slots 13 and 15 set address bits 7:0.
- R3: A data read of slots 0 to 11 (write-only) or 18 to 31 (reserved) returns 0x00.
- R4: A data read of slots 12 to 15 returns the stored address byte. Slots 12 and 14 return address bits 13:8 in bits 5:0, with bits 7:6 zero. Slots 13 and 15 return address bits 7:0.
- R5: A data write to slots 16 to 31 changes no output and no readable value.
- R6: Read data appears on `rdata` one cycle after the read strobe and holds until the next read.
- R7: A read of the index location returns status. Bit 5 is 1 when `vrow` is greater than or equal to slot 6. Bit 6 is the light-pen flag. All other bits are 0.
- R8: `lpen_n` passes through two synchronising flops. The rising edge of the synchronised active-high strobe captures `refresh_addr` and sets the flag. A fall of `lpen_n` sampled at edge k is captured at edge k+2.
- R9: A data read of slot 16 or 17 clears the flag. If a capture happens on the same edge, the set wins.
- R10: A data read of slot 16 returns captured bits 13:8 in bits 5:0, with bits 7:6 zero. A data read of slot 17 returns captured bits 7:0.
- R11: Reset clears every slot, the index, the captured address, the flag and `rdata` to zero.
- R12: When a read and a write of the data location fall on the same edge, the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_sel | input | 1 | 0 selects the index/status location, 1 selects the data location |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| lpen_n | input | 1 | Asynchronous active-low light-pen strobe |
| vrow | input | 7 | Current character-row count from the timing generator |
| refresh_addr | input | 14 | Live refresh address from the timing generator |
| h_total | output | 8 | Slot 0 value |
| h_disp | output | 8 | Slot 1 value |
| h_sync_pos | output | 8 | Slot 2 value |
| sync_widths | output | 8 | Slot 3 value |
| v_total | output | 7 | Slot 4 value |
| v_adjust | output | 5 | Slot 5 value |
| v_disp | output | 7 | Slot 6 value |
| v_sync_pos | output | 7 | Slot 7 value |
| mode_ctl | output | 8 | Slot 8 value |
| row_scans | output | 5 | Slot 9 value |
| cur_start | output | 7 | Slot 10 value |
| cur_end | output | 5 | Slot 11 value |
| start_addr | output | 14 | Slots 12 and 13 as one address |
| cursor_addr | output | 14 | Slots 14 and 15 as one address |

## Verification
A write shows on the slot outputs one edge after the write strobe is sampled. A read shows on `rdata` one edge after the read strobe, and a status read reflects the flag and `vrow` as they stood at that edge. A light-pen fall first acts two edges after it is sampled. The capture and the flag therefore become visible after the third edge, counting from the edge that first sees the strobe low. The bench steps a behavioural model on every rising edge, in these same edge counts. It compares every output 3 ns after the edge, so each result is checked in the cycle it is due. Strobe pulses are placed at varying offsets against slot-16 reads, so the edge where a capture and a clear coincide is also covered.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    localparam int DATA_W = 8;
    localparam int IDX_W  = 5;
    localparam int ADDR_W = 14;
    localparam int VROW_W = 7;
    localparam int HI_W   = ADDR_W - DATA_W;

    localparam logic [IDX_W-1:0] SL_HTOT    = 5'd0;
    localparam logic [IDX_W-1:0] SL_HVIS    = 5'd1;
    localparam logic [IDX_W-1:0] SL_HSPOS   = 5'd2;
    localparam logic [IDX_W-1:0] SL_SYNCW   = 5'd3;
    localparam logic [IDX_W-1:0] SL_VTOT    = 5'd4;
    localparam logic [IDX_W-1:0] SL_VADJ    = 5'd5;
    localparam logic [IDX_W-1:0] SL_VVIS    = 5'd6;
    localparam logic [IDX_W-1:0] SL_VSPOS   = 5'd7;
    localparam logic [IDX_W-1:0] SL_MODE    = 5'd8;
    localparam logic [IDX_W-1:0] SL_ROWS    = 5'd9;
    localparam logic [IDX_W-1:0] SL_CTOP    = 5'd10;
    localparam logic [IDX_W-1:0] SL_CBOT    = 5'd11;
    localparam logic [IDX_W-1:0] SL_BASE_HI = 5'd12;
    localparam logic [IDX_W-1:0] SL_BASE_LO = 5'd13;
    localparam logic [IDX_W-1:0] SL_CUR_HI  = 5'd14;
    localparam logic [IDX_W-1:0] SL_CUR_LO  = 5'd15;
    localparam logic [IDX_W-1:0] SL_PEN_HI  = 5'd16;
    localparam logic [IDX_W-1:0] SL_PEN_LO  = 5'd17;

    localparam int ST_VBLANK_BIT = 5;
    localparam int ST_PEN_BIT    = 6;

    typedef struct packed {
        logic [7:0]        h_total;
        logic [7:0]        h_disp;
        logic [7:0]        h_sync_pos;
        logic [7:0]        sync_widths;
        logic [6:0]        v_total;
        logic [4:0]        v_adjust;
        logic [6:0]        v_disp;
        logic [6:0]        v_sync_pos;
        logic [7:0]        mode_ctl;
        logic [4:0]        row_scans;
        logic [6:0]        cur_start;
        logic [4:0]        cur_end;
        logic [ADDR_W-1:0] start_addr;
        logic [ADDR_W-1:0] cursor_addr;
    } crtc_cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              flag;
    } pen_state_t;

    function automatic logic [DATA_W-1:0] hi_byte(input logic [ADDR_W-1:0] a);
        return {{(DATA_W-HI_W){1'b0}}, a[ADDR_W-1:DATA_W]};
    endfunction

    function automatic logic [DATA_W-1:0] lo_byte(input logic [ADDR_W-1:0] a);
        return a[DATA_W-1:0];
    endfunction

    function automatic logic [DATA_W-1:0] make_status(input logic vblank, input logic pen);
        logic [DATA_W-1:0] s;
        s = '0;
        s[ST_VBLANK_BIT] = vblank;
        s[ST_PEN_BIT]    = pen;
        return s;
    endfunction

endpackage

// File: rtl/crtc_pen_sync.sv
module crtc_pen_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic rise
);
    localparam int LAST = STAGES;

    logic [LAST:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain[0] <= 1'b0;
        else     chain[0] <= ~strobe_n;
    end

    genvar g;
    generate
        for (g = 1; g <= LAST; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[g] <= 1'b0;
                else     chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign rise = chain[LAST-1] & ~chain[LAST];

endmodule

// File: rtl/crtc_reg_bank.sv
module crtc_reg_bank
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output crtc_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (idx)
                SL_HTOT:    cfg.h_total     <= wdata;
                SL_HVIS:    cfg.h_disp      <= wdata;
                SL_HSPOS:   cfg.h_sync_pos  <= wdata;
                SL_SYNCW:   cfg.sync_widths <= wdata;
                SL_VTOT:    cfg.v_total     <= wdata[6:0];
                SL_VADJ:    cfg.v_adjust    <= wdata[4:0];
                SL_VVIS:    cfg.v_disp      <= wdata[6:0];
                SL_VSPOS:   cfg.v_sync_pos  <= wdata[6:0];
                SL_MODE:    cfg.mode_ctl    <= wdata;
                SL_ROWS:    cfg.row_scans   <= wdata[4:0];
                SL_CTOP:    cfg.cur_start   <= wdata[6:0];
                SL_CBOT:    cfg.cur_end     <= wdata[4:0];
                SL_BASE_HI: cfg.start_addr[ADDR_W-1:DATA_W]  <= wdata[HI_W-1:0];
                SL_BASE_LO: cfg.start_addr[DATA_W-1:0]       <= wdata;
                SL_CUR_HI:  cfg.cursor_addr[ADDR_W-1:DATA_W] <= wdata[HI_W-1:0];
                SL_CUR_LO:  cfg.cursor_addr[DATA_W-1:0]      <= wdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/crtc_read_path.sv
module crtc_read_path
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic              addr_sel,
    input  logic [IDX_W-1:0]  idx,
    input  crtc_cfg_t         cfg,
    input  pen_state_t        pen,
    input  logic [VROW_W-1:0] vrow,
    output logic [DATA_W-1:0] rdata
);
    logic              vblank;
    logic [DATA_W-1:0] slot_val;
    logic [DATA_W-1:0] next_val;

    assign vblank = (vrow >= cfg.v_disp);

    always_comb begin
        case (idx)
            SL_BASE_HI: slot_val = hi_byte(cfg.start_addr);
            SL_BASE_LO: slot_val = lo_byte(cfg.start_addr);
            SL_CUR_HI:  slot_val = hi_byte(cfg.cursor_addr);
            SL_CUR_LO:  slot_val = lo_byte(cfg.cursor_addr);
            SL_PEN_HI:  slot_val = hi_byte(pen.addr);
            SL_PEN_LO:  slot_val = lo_byte(pen.addr);
            default:    slot_val = '0;
        endcase
    end

    assign next_val = addr_sel ? slot_val : make_status(vblank, pen.flag);

    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (rd) rdata <= next_val;
    end

endmodule

// File: rtl/crtc_regfile.sv
module crtc_regfile
    import crtc_pkg::*;
#(
    parameter int PEN_SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                addr_sel,
    input  logic                wr,
    input  logic                rd,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata,
    input  logic                lpen_n,
    input  logic [VROW_W-1:0]   vrow,
    input  logic [ADDR_W-1:0]   refresh_addr,
    output logic [7:0]          h_total,
    output logic [7:0]          h_disp,
    output logic [7:0]          h_sync_pos,
    output logic [7:0]          sync_widths,
    output logic [6:0]          v_total,
    output logic [4:0]          v_adjust,
    output logic [6:0]          v_disp,
    output logic [6:0]          v_sync_pos,
    output logic [7:0]          mode_ctl,
    output logic [4:0]          row_scans,
    output logic [6:0]          cur_start,
    output logic [4:0]          cur_end,
    output logic [ADDR_W-1:0]   start_addr,
    output logic [ADDR_W-1:0]   cursor_addr
);
    logic [IDX_W-1:0] idx_q;
    crtc_cfg_t        cfg;
    pen_state_t       pen_q;
    logic             pen_rise;
    logic             pen_flag;
    logic             pen_clear;

    always_ff @(posedge clk) begin
        if (rst)                   idx_q <= '0;
        else if (wr && !addr_sel)  idx_q <= wdata[IDX_W-1:0];
    end

    crtc_reg_bank u_bank (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr && addr_sel),
        .idx   (idx_q),
        .wdata (wdata),
        .cfg   (cfg)
    );

    crtc_pen_sync #(.STAGES(PEN_SYNC_STAGES)) u_pen (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (lpen_n),
        .rise     (pen_rise)
    );

    assign pen_clear = rd && addr_sel && ((idx_q == SL_PEN_HI) || (idx_q == SL_PEN_LO));

    always_ff @(posedge clk) begin
        if (rst) begin
            pen_q <= '0;
        end else if (pen_rise) begin
            pen_q.addr <= refresh_addr;
            pen_q.flag <= 1'b1;
        end else if (pen_clear) begin
            pen_q.flag <= 1'b0;
        end
    end

    assign pen_flag = pen_q.flag;

    crtc_read_path u_read (
        .clk      (clk),
        .rst      (rst),
        .rd       (rd),
        .addr_sel (addr_sel),
        .idx      (idx_q),
        .cfg      (cfg),
        .pen      (pen_q),
        .vrow     (vrow),
        .rdata    (rdata)
    );

    assign h_total     = cfg.h_total;
    assign h_disp      = cfg.h_disp;
    assign h_sync_pos  = cfg.h_sync_pos;
    assign sync_widths = cfg.sync_widths;
    assign v_total     = cfg.v_total;
    assign v_adjust    = cfg.v_adjust;
    assign v_disp      = cfg.v_disp;
    assign v_sync_pos  = cfg.v_sync_pos;
    assign mode_ctl    = cfg.mode_ctl;
    assign row_scans   = cfg.row_scans;
    assign cur_start   = cfg.cur_start;
    assign cur_end     = cfg.cur_end;
    assign start_addr  = cfg.start_addr;
    assign cursor_addr = cfg.cursor_addr;

endmodule

// File: rtl/crtc_regfile_chk.sv
module crtc_regfile_chk (
    input logic        clk,
    input logic        rst,
    input logic        addr_sel,
    input logic        wr,
    input logic        rd,
    input logic [7:0]  rdata,
    input logic [4:0]  idx_q,
    input logic        pen_rise,
    input logic        pen_flag,
    input logic [7:0]  h_total,
    input logic [13:0] start_addr,
    input logic [13:0] cursor_addr
);
    assert_reset_clear_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (rdata == 8'h00 && h_total == 8'h00 && start_addr == 14'h0
                        && idx_q == 5'd0 && !pen_flag));

    assert_hidden_read_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (rd && addr_sel && (idx_q < 5'd12 || idx_q > 5'd17)) |=> (rdata == 8'h00));

    assert_ignored_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr && addr_sel && idx_q >= 5'd16) |=>
        ($stable(h_total) && $stable(start_addr) && $stable(cursor_addr)));

    assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !rd |=> $stable(rdata));

    assert_status_unused_bits_R7: assert property (@(posedge clk) disable iff (rst)
        (rd && !addr_sel) |=> (rdata[7] == 1'b0 && rdata[4:0] == 5'd0));

    assert_pen_set_R8: assert property (@(posedge clk) disable iff (rst)
        pen_rise |=> pen_flag);

    assert_pen_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (rd && addr_sel && (idx_q == 5'd16 || idx_q == 5'd17) && !pen_rise) |=> !pen_flag);

endmodule

bind crtc_regfile crtc_regfile_chk u_chk (.*);

// File: tb/crtc_regfile_test.sv
module crtc_regfile_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        addr_sel = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic        lpen_n = 1'b1;
    logic [6:0]  vrow = 7'd0;
    logic [13:0] refresh_addr = 14'h0;
    logic [7:0]  h_total, h_disp, h_sync_pos, sync_widths, mode_ctl;
    logic [6:0]  v_total, v_disp, v_sync_pos, cur_start;
    logic [4:0]  v_adjust, row_scans, cur_end;
    logic [13:0] start_addr, cursor_addr;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    crtc_regfile uut (
        .clk(clk), .rst(rst), .addr_sel(addr_sel), .wr(wr), .rd(rd),
        .wdata(wdata), .rdata(rdata), .lpen_n(lpen_n), .vrow(vrow),
        .refresh_addr(refresh_addr), .h_total(h_total), .h_disp(h_disp),
        .h_sync_pos(h_sync_pos), .sync_widths(sync_widths), .v_total(v_total),
        .v_adjust(v_adjust), .v_disp(v_disp), .v_sync_pos(v_sync_pos),
        .mode_ctl(mode_ctl), .row_scans(row_scans), .cur_start(cur_start),
        .cur_end(cur_end), .start_addr(start_addr), .cursor_addr(cursor_addr)
    );

    // behavioural reference model
    int    m_reg [0:15];
    int    m_idx, m_lp, m_flag, m_rdata;
    int    p1, p2, p3;
    string m_rtag = "R11";

    function automatic int slot_mask(input int i);
        if (i == 4 || i == 6 || i == 7 || i == 10) return 'h7F;
        if (i == 5 || i == 9 || i == 11)           return 'h1F;
        if (i == 12 || i == 14)                    return 'h3F;
        return 'hFF;
    endfunction

    function automatic int model_slot(input int i);
        if (i >= 12 && i <= 15) return m_reg[i];
        if (i == 16) return (m_lp >> 8) & 'h3F;
        if (i == 17) return m_lp & 'hFF;
        return 0;
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int rise, clr;
        if (rst) begin
            for (int i = 0; i < 16; i++) m_reg[i] = 0;
            m_idx = 0; m_lp = 0; m_flag = 0; m_rdata = 0;
            p1 = 0; p2 = 0; p3 = 0;
            m_rtag = "R11";
        end else begin
            rise = (p2 != 0 && p3 == 0) ? 1 : 0;
            clr = 0;
            if (rd) begin
                if (!addr_sel) begin
                    m_rdata = ((int'(vrow) >= m_reg[6]) ? 32 : 0) | (m_flag ? 64 : 0);
                    m_rtag = "R7";
                end else begin
                    m_rdata = model_slot(m_idx);   // pre-write value, R12
                    if (m_idx >= 12 && m_idx <= 15)      m_rtag = "R4";
                    else if (m_idx == 16 || m_idx == 17) m_rtag = "R10";
                    else                                 m_rtag = "R3";
                    if (m_idx == 16 || m_idx == 17) clr = 1;
                end
            end else begin
                m_rtag = "R6";
            end
            if (wr) begin
                if (!addr_sel)        m_idx = int'(wdata) & 'h1F;
                else if (m_idx < 16)  m_reg[m_idx] = int'(wdata) & slot_mask(m_idx);
            end
            if (rise != 0) begin
                m_lp = int'(refresh_addr);
                m_flag = 1;
            end else if (clr != 0) begin
                m_flag = 0;
            end
            p3 = p2; p2 = p1; p1 = lpen_n ? 0 : 1;
        end
        #3;
        cmp(m_rtag, "rdata", int'(rdata), m_rdata);
        cmp("R2", "h_total", int'(h_total), m_reg[0]);
        cmp("R2", "h_disp", int'(h_disp), m_reg[1]);
        cmp("R2", "h_sync_pos", int'(h_sync_pos), m_reg[2]);
        cmp("R2", "sync_widths", int'(sync_widths), m_reg[3]);
        cmp("R2", "v_total", int'(v_total), m_reg[4]);
        cmp("R2", "v_adjust", int'(v_adjust), m_reg[5]);
        cmp("R2", "v_disp", int'(v_disp), m_reg[6]);
        cmp("R2", "v_sync_pos", int'(v_sync_pos), m_reg[7]);
        cmp("R2", "mode_ctl", int'(mode_ctl), m_reg[8]);
        cmp("R2", "row_scans", int'(row_scans), m_reg[9]);
        cmp("R2", "cur_start", int'(cur_start), m_reg[10]);
        cmp("R2", "cur_end", int'(cur_end), m_reg[11]);
        cmp("R2", "start_addr", int'(start_addr), (m_reg[12] << 8) | m_reg[13]);
        cmp("R2", "cursor_addr", int'(cursor_addr), (m_reg[14] << 8) | m_reg[15]);
    end

    task automatic bus(input logic w, input logic r, input logic a, input logic [7:0] d);
        @(negedge clk);
        wr = w; rd = r; addr_sel = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
    endtask

    task automatic put(input int slot, input int val);
        bus(1'b1, 1'b0, 1'b0, 8'(slot));
        bus(1'b1, 1'b0, 1'b1, 8'(val));
    endtask

    task automatic get(input int slot);
        bus(1'b1, 1'b0, 1'b0, 8'(slot));
        bus(1'b0, 1'b1, 1'b1, 8'h00);
    endtask

    task automatic pen_pulse(input int hold);
        @(negedge clk);
        lpen_n = 1'b0;
        repeat (hold) @(negedge clk);
        lpen_n = 1'b1;
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R6 actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cmp("R11", "rdata after reset", int'(rdata), 0);
        cmp("R11", "start_addr after reset", int'(start_addr), 0);

        // distinct patterns into every storing slot, then read all 32
        for (int i = 0; i < 16; i++) put(i, (i * 37 + 'h5A) & 'hFF);
        for (int i = 0; i < 32; i++) get(i);
        // all ones everywhere, reserved and read-only slots included (R5)
        for (int i = 0; i < 32; i++) put(i, 'hFF);
        for (int i = 0; i < 32; i++) get(i);
        get(16);
        cmp("R5", "slot16 after write", int'(rdata), 0);

        // index upper bits ignored: 0xEC selects slot 12
        bus(1'b1, 1'b0, 1'b0, 8'hEC);
        bus(1'b1, 1'b0, 1'b1, 8'h2A);
        cmp("R1", "start_addr[13:8]", int'(start_addr[13:8]), 'h2A);

        // read and write of the data location on the same edge
        bus(1'b1, 1'b1, 1'b1, 8'h15);
        cmp("R12", "read during write", int'(rdata), 'h2A);
        cmp("R12", "write landed", int'(start_addr[13:8]), 'h15);

        // vertical blanking status around the displayed-row boundary
        put(6, 25);
        foreach (vrow_set[k]) begin
            vrow = 7'(vrow_set[k]);
            bus(1'b0, 1'b1, 1'b0, 8'h00);
            cmp("R7", "vblank bit", int'(rdata[5]), (vrow_set[k] >= 25) ? 1 : 0);
        end

        // light pen capture, status and clearing
        refresh_addr = 14'h1234;
        pen_pulse(4);
        refresh_addr = 14'h0777;
        repeat (3) @(negedge clk);
        bus(1'b0, 1'b1, 1'b0, 8'h00);
        cmp("R8", "pen flag set", int'(rdata[6]), 1);
        get(16);
        cmp("R10", "pen high", int'(rdata), 'h12);
        bus(1'b0, 1'b1, 1'b0, 8'h00);
        cmp("R9", "pen flag cleared", int'(rdata[6]), 0);
        get(17);
        cmp("R10", "pen low", int'(rdata), 'h34);

        // pulses landing at several offsets against slot-16 reads
        for (int j = 0; j < 6; j++) begin
            refresh_addr = 14'(('h0A5 * (j + 3)) & 'h3FFF);
            bus(1'b1, 1'b0, 1'b0, 8'd16);
            @(negedge clk);
            lpen_n = 1'b0;
            repeat (j) @(negedge clk);
            bus(1'b0, 1'b1, 1'b1, 8'h00);
            lpen_n = 1'b1;
            repeat (4) @(negedge clk);
            bus(1'b0, 1'b1, 1'b0, 8'h00);
        end

        // a short pulse of a single cycle still captures
        refresh_addr = 14'h3FFF;
        pen_pulse(1);
        repeat (4) @(negedge clk);
        get(17);
        cmp("R8", "one-cycle pulse", int'(rdata), 'hFF);

        // reset in the middle of activity
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        cmp("R11", "cursor_addr after reset", int'(cursor_addr), 0);
        bus(1'b0, 1'b1, 1'b0, 8'h00);
        repeat (2) @(negedge clk);
        finish_run();
    end

    int vrow_set [5] = '{0, 24, 25, 26, 127};

endmodule